// File: doc/BRIEF.md
# RNS Base Extension Unit

This block takes an integer held as residues over a source set of pairwise coprime moduli. It produces the residues of that integer over a second set of moduli that is coprime to the first. It does not rebuild the integer in binary. It follows the Chinese-remainder sum. First, each source residue is scaled by the modular inverse of its cofactor. The top bits of each scaled residue then feed a small fractional accumulator. That accumulator decides, one source channel at a time, whether a copy of the source modulus product has to be taken away. Each destination channel holds its own modular accumulator. It adds the scaled residue weighted by the cofactor reduced to its modulus, plus the correction term when the one-bit quotient fires.

The integer quotient is only estimated from truncated bits. The result is therefore either the value X itself or X + Ma, where Ma is the product of the source moduli, and it is the same choice in every destination channel. Multiply-based algorithms built on this step can absorb that ambiguity. All moduli have the form 2^W − h with h < 2^(W/2). Every modular product is reduced by folding the high half back through h, so no divider is used. Word width, the channel counts, the number of truncated bits, the starting offset of the accumulator and both moduli lists are parameters. All per-modulus constants are derived from them at elaboration.

Top module: `rns_bx_unit`

## Requirements
- R1: After reset, busy_o and done_o are low and y_o is all zeros.
- R2: start_i high at a rising edge while busy_o is low captures x_i and starts a conversion; busy_o is high from the next cycle until the result is ready.
- R3: done_o is high for exactly one cycle, in the cycle that follows the (NA+1)-th rising edge after the accepting edge; busy_o is low in that cycle.
- R4: Source residue i is the field x_i[i*W +: W] and destination residue j is the field y_o[j*W +: W]. For a value X < Ma whose source residues are X mod m_a,i, every field j of y_o equals X mod m_b,j, or every field j equals (X + Ma) mod m_b,j.
- R5: Every destination field on done_o is below its modulus m_b,j.
- R6: With all source residues zero, y_o is exactly all zeros.
- R7: start_i while busy_o is high is ignored: no extra completion follows, and the result is that of the captured operand even if x_i changes.
- R8: y_o keeps its value while the unit is idle, until the next conversion is accepted.
- R9: A conversion accepted in the done_o cycle of the previous one completes with a correct result.
- R10: The largest operand X = Ma − 1 gives a result that meets R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a conversion when idle |
| x_i | input | NA*W | Source residues, channel i at bits i*W +: W |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | NB*W | Destination residues, channel j at bits j*W +: W |

## Verification
The assertions assume that each source residue is already below its own modulus and that the parameter moduli are of the stated 2^W − h form and pairwise coprime. Under these conditions the folded reduction always lands in range, and the estimated quotient is off by at most one copy of Ma. The bench builds every operand as an integer below Ma and derives the residues by exact division on wide integers. It therefore never drives a residue out of range. The moduli it passes are distinct primes of the required form. Stray start pulses fall only in busy cycles, so they test the ignore rule without breaking the input assumptions.

// File: rtl/rns_bx_pkg.sv
package rns_bx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FEED,
    ST_DRAIN
  } bx_state_e;

  // (a*b) mod m, operands below 2^31
  function automatic longint mul_mod(input longint a, input longint b, input longint m);
    return (a * b) % m;
  endfunction

  // modular inverse by extended Euclid
  function automatic longint inv_mod(input longint a, input longint m);
    longint t, nt, r, nr, qq, tmp;
    t  = 0;
    nt = 1;
    r  = m;
    nr = a % m;
    while (nr != 0) begin
      qq  = r / nr;
      tmp = t - qq * nt;
      t   = nt;
      nt  = tmp;
      tmp = r - qq * nr;
      r   = nr;
      nr  = tmp;
    end
    if (t < 0) t = t + m;
    return t;
  endfunction

endpackage

// File: rtl/rns_bx_modred.sv
// Reduce a 2W-bit value modulo m = 2^W - h with h < 2^(W/2): three folds, one subtract.
module rns_bx_modred #(
  parameter int W  = 16,
  parameter int HW = W / 2
) (
  input  logic [2*W-1:0] p_i,
  input  logic [W-1:0]   m_i,
  input  logic [HW-1:0]  h_i,
  output logic [W-1:0]   r_o
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] LO_MASK = (PW'(1) << W) - PW'(1);

  logic [PW-1:0] hx, mx, t1, t2, t3;

  assign hx = PW'(h_i);
  assign mx = PW'(m_i);
  assign t1 = (p_i >> W) * hx + (p_i & LO_MASK);
  assign t2 = (t1 >> W) * hx + (t1 & LO_MASK);
  assign t3 = (t2 >> W) * hx + (t2 & LO_MASK);
  assign r_o = (t3 >= mx) ? W'(t3 - mx) : W'(t3);

endmodule

// File: rtl/rns_bx_cox.sv
// Fractional quotient estimator: one integer bit over T fraction bits.
module rns_bx_cox #(
  parameter int T = 6,
  parameter logic [T-1:0] SIGMA0 = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         step_i,
  input  logic [T-1:0] frac_i,
  output logic         q_o
);
  logic [T-1:0] sigma_q;
  logic [T:0]   sum;

  assign sum = {1'b0, sigma_q} + {1'b0, frac_i};
  assign q_o = sum[T];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sigma_q <= SIGMA0;
    else if (init_i) sigma_q <= SIGMA0;
    else if (step_i) sigma_q <= sum[T-1:0];
  end

endmodule

// File: rtl/rns_bx_dest_ch.sv
// One destination channel: acc = acc + xi*coef + q*neg_ma (mod m).
module rns_bx_dest_ch #(
  parameter int W  = 16,
  parameter int HW = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [W-1:0]  xi_i,
  input  logic [W-1:0]  coef_i,
  input  logic [W-1:0]  neg_ma_i,
  input  logic [W-1:0]  m_i,
  input  logic [HW-1:0] h_i,
  input  logic          q_i,
  output logic [W-1:0]  acc_o
);
  logic [2*W-1:0] prod;
  logic [W-1:0]   term, s1r, corr, acc_d, acc_q;
  logic [W:0]     s1, s2, mw;

  assign prod = (2*W)'(xi_i) * (2*W)'(coef_i);

  rns_bx_modred #(.W(W), .HW(HW)) u_red (
    .p_i (prod),
    .m_i (m_i),
    .h_i (h_i),
    .r_o (term)
  );

  assign mw    = {1'b0, m_i};
  assign s1    = {1'b0, acc_q} + {1'b0, term};
  assign s1r   = (s1 >= mw) ? W'(s1 - mw) : W'(s1);
  assign corr  = q_i ? neg_ma_i : '0;
  assign s2    = {1'b0, s1r} + {1'b0, corr};
  assign acc_d = (s2 >= mw) ? W'(s2 - mw) : W'(s2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/rns_bx_unit.sv
module rns_bx_unit #(
  parameter int W  = 16,
  parameter int NA = 4,
  parameter int NB = 4,
  parameter int T  = 6,
  parameter logic [T-1:0]    SIGMA0 = '0,
  parameter logic [NA*W-1:0] MOD_A  = {16'd65479, 16'd65497, 16'd65519, 16'd65521},
  parameter logic [NB*W-1:0] MOD_B  = {16'd65423, 16'd65437, 16'd65447, 16'd65449}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NA*W-1:0] x_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [NB*W-1:0] y_o
);
  import rns_bx_pkg::*;

  localparam int HW = W / 2;
  localparam int IW = (NA > 1) ? $clog2(NA) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NA - 1);

  function automatic longint mod_a(input int i);
    return longint'(MOD_A[i*W +: W]);
  endfunction

  function automatic longint mod_b(input int j);
    return longint'(MOD_B[j*W +: W]);
  endfunction

  // product of source moduli except channel skip, reduced mod m
  function automatic longint cofactor_mod(input int skip, input longint m);
    longint p;
    p = 1 % m;
    for (int k = 0; k < NA; k++)
      if (k != skip) p = mul_mod(p, mod_a(k) % m, m);
    return p;
  endfunction

  // elaboration-time constant tables
  logic [W-1:0]  inv_tab  [NA];
  logic [W-1:0]  ma_tab   [NA];
  logic [HW-1:0] ha_tab   [NA];
  logic [W-1:0]  coef_tab [NA][NB];
  logic [W-1:0]  mb_tab   [NB];
  logic [HW-1:0] hb_tab   [NB];
  logic [W-1:0]  nma_tab  [NB];

  for (genvar i = 0; i < NA; i++) begin : g_src_const
    localparam longint MI  = mod_a(i);
    localparam longint INV = inv_mod(cofactor_mod(i, MI), MI);
    assign inv_tab[i] = W'(INV);
    assign ma_tab[i]  = W'(MI);
    assign ha_tab[i]  = HW'((longint'(1) << W) - MI);
    for (genvar j = 0; j < NB; j++) begin : g_coef
      assign coef_tab[i][j] = W'(cofactor_mod(i, mod_b(j)));
    end
  end

  for (genvar j = 0; j < NB; j++) begin : g_dst_const
    localparam longint MJ  = mod_b(j);
    localparam longint NMA = (MJ - cofactor_mod(-1, MJ)) % MJ;
    assign mb_tab[j]  = W'(MJ);
    assign hb_tab[j]  = HW'((longint'(1) << W) - MJ);
    assign nma_tab[j] = W'(NMA);
  end

  // control
  bx_state_e     state_q;
  logic [IW-1:0] idx_q, idx1_q;
  logic          v1_q, done_q, accept;
  logic [W-1:0]  x_q [NA];
  logic [W-1:0]  xi_d, xi_q;
  logic [2*W-1:0] scale_prod;
  logic          q_bit;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      idx1_q  <= '0;
      v1_q    <= 1'b0;
      done_q  <= 1'b0;
      xi_q    <= '0;
      for (int i = 0; i < NA; i++) x_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          v1_q <= 1'b0;
          if (start_i) begin
            for (int i = 0; i < NA; i++) x_q[i] <= x_i[i*W +: W];
            idx_q   <= '0;
            state_q <= ST_FEED;
          end
        end
        ST_FEED: begin
          v1_q   <= 1'b1;
          idx1_q <= idx_q;
          xi_q   <= xi_d;
          if (idx_q == LAST_IDX) state_q <= ST_DRAIN;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_DRAIN: begin
          v1_q    <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // stage 1: scale residue by inverse cofactor
  assign scale_prod = (2*W)'(x_q[idx_q]) * (2*W)'(inv_tab[idx_q]);

  rns_bx_modred #(.W(W), .HW(HW)) u_scale (
    .p_i (scale_prod),
    .m_i (ma_tab[idx_q]),
    .h_i (ha_tab[idx_q]),
    .r_o (xi_d)
  );

  // stage 2: quotient estimate and destination update
  rns_bx_cox #(.T(T), .SIGMA0(SIGMA0)) u_cox (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (accept),
    .step_i (v1_q),
    .frac_i (xi_q[W-1 -: T]),
    .q_o    (q_bit)
  );

  for (genvar j = 0; j < NB; j++) begin : g_dst
    logic [W-1:0] acc;
    rns_bx_dest_ch #(.W(W), .HW(HW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (accept),
      .en_i     (v1_q),
      .xi_i     (xi_q),
      .coef_i   (coef_tab[idx1_q][j]),
      .neg_ma_i (nma_tab[j]),
      .m_i      (mb_tab[j]),
      .h_i      (hb_tab[j]),
      .q_i      (q_bit),
      .acc_o    (acc)
    );
    assign y_o[j*W +: W] = acc;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/rns_bx_unit_chk.sv
module rns_bx_unit_chk #(
  parameter int W  = 16,
  parameter int NA = 4,
  parameter int NB = 4,
  parameter logic [NB*W-1:0] MOD_B = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [NB*W-1:0] y_o
);
  logic [15:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= '0;
    else if (!busy_o && start_i)  lat_q <= '0;
    else if (busy_o)              lat_q <= lat_q + 16'd1;
  end

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r3_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == 16'(NA + 1)));

  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(y_o));

  for (genvar j = 0; j < NB; j++) begin : g_rng
    a_r5_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (y_o[j*W +: W] < MOD_B[j*W +: W]));
  end

endmodule

bind rns_bx_unit rns_bx_unit_chk #(
  .W(W), .NA(NA), .NB(NB), .MOD_B(MOD_B)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .y_o     (y_o)
);

// File: tb/rns_bx_unit_bench.sv
module rns_bx_unit_bench;
  localparam int W  = 16;
  localparam int NA = 4;
  localparam int NB = 4;
  localparam logic [NA*W-1:0] MA_LIST = {16'd65479, 16'd65497, 16'd65519, 16'd65521};
  localparam logic [NB*W-1:0] MB_LIST = {16'd65423, 16'd65437, 16'd65447, 16'd65449};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [NA*W-1:0] x_i = '0;
  logic          busy_o, done_o;
  logic [NB*W-1:0] y_o;

  rns_bx_unit #(.W(W), .NA(NA), .NB(NB), .MOD_A(MA_LIST), .MOD_B(MB_LIST)) u_rns_bx_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .x_i(x_i),
    .busy_o(busy_o), .done_o(done_o), .y_o(y_o)
  );

  always #2 clk_i = ~clk_i;

  int     n_chk = 0, n_fail = 0;
  bit     finished = 0;
  longint cyc = 0;
  logic [NB*W-1:0] exp_x_q [$];
  logic [NB*W-1:0] exp_xm_q [$];
  longint          t0_q [$];
  string           req_q [$];
  logic [NB*W-1:0] last_y = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] ma_all();
    logic [127:0] p = 128'd1;
    for (int i = 0; i < NA; i++) p = p * 128'(MA_LIST[i*W +: W]);
    return p;
  endfunction

  function automatic logic [NB*W-1:0] dest_res(input logic [127:0] v);
    logic [NB*W-1:0] r;
    for (int j = 0; j < NB; j++) r[j*W +: W] = W'(v % 128'(MB_LIST[j*W +: W]));
    return r;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // driver: push expected item and start a conversion
  task automatic run_op(input logic [127:0] xv, input string req, input bit exact);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    for (int i = 0; i < NA; i++) x_i[i*W +: W] = W'(xv % 128'(MA_LIST[i*W +: W]));
    start_i = 1'b1;
    exp_x_q.push_back(dest_res(xv));
    exp_xm_q.push_back(exact ? dest_res(xv) : dest_res(xv + ma_all()));
    req_q.push_back(req);
    @(negedge clk_i);
    t0_q.push_back(cyc);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after accept", 128'(busy_o), 128'd1);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_x_q.size() == 0) begin
        check(1'b0, "R7", "unexpected done", 128'd1, 128'd0);
      end else begin
        logic [NB*W-1:0] ex, exm;
        longint t0;
        string rq;
        ex = exp_x_q.pop_front();
        exm = exp_xm_q.pop_front();
        t0 = t0_q.pop_front();
        rq = req_q.pop_front();
        check((y_o == ex) || (y_o == exm), rq, "residues (R4)", 128'(y_o), 128'(ex));
        check(cyc == t0 + NA + 1, "R3", "done timing", 128'(cyc - t0), 128'(NA + 1));
        check(!busy_o, "R3", "busy low at done", 128'(busy_o), 128'd0);
        for (int j = 0; j < NB; j++)
          check(y_o[j*W +: W] < MB_LIST[j*W +: W], "R5", "range",
                128'(y_o[j*W +: W]), 128'(MB_LIST[j*W +: W]));
        last_y = y_o;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] ma;
    ma = ma_all();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o == 1'b0, "R1", "busy reset", 128'(busy_o), 128'd0);
    check(done_o == 1'b0, "R1", "done reset", 128'(done_o), 128'd0);
    check(y_o == '0, "R1", "y reset", 128'(y_o), 128'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_op(128'd0, "R6", 1'b1);
    run_op(128'd1, "R4", 1'b0);
    run_op(ma - 128'd1, "R10", 1'b0);
    run_op(ma >> 1, "R4", 1'b0);
    for (int k = 0; k < 20; k++) begin
      logic [127:0] xv;
      xv = {32'h0, $urandom(), $urandom(), $urandom()} % ma;
      run_op(xv, "R9", 1'b0);
    end

    // R7: stray start with a different operand while busy
    run_op(128'd123456789, "R7", 1'b0);
    @(negedge clk_i);
    x_i = '1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o || exp_x_q.size() != 0) @(negedge clk_i);

    // R8: output held while idle
    repeat (6) @(negedge clk_i);
    check(y_o == last_y, "R8", "hold while idle", 128'(y_o), 128'(last_y));
    check(!busy_o && !done_o, "R7", "no extra run", 128'({busy_o, done_o}), 128'd0);

    run_op(128'd0, "R6", 1'b1);
    while (busy_o || exp_x_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    finish_run();
  end

endmodule